// File: doc/BRIEF.md
# Error-Checked Memory Acknowledge Controller

This block is the slave-side handshake logic for a memory that has an error checker on its read path, sitting on an asynchronous 16-bit processor bus. A cycle opens when the address strobe, the chip select and at least one data strobe are all active. The controller then pulses the memory read enable, or the write enables of the selected byte lanes. Writes are acknowledged as soon as the data has been latched. Reads hold back the data acknowledge until the external checker reports that the word on the bus has been verified.

When the checker flags bad data, the cycle is closed in one of two ways, chosen by a mode input. In retry mode, bus-error and halt are asserted together, so the processor reruns the cycle. In abort mode, bus-error is asserted in the same clock as the acknowledge. A retried cycle repeats the memory access. Consecutive retries are counted, and once the count reaches a parameterised limit the next error is closed as an abort, whatever the mode input says.

The three responses are active low. They are gated by both the address strobe and the chip select, so they release as soon as the bus master negates its strobe. All inputs are assumed to be synchronous to `clk`.

Top module: `chkAckCtrl`

## Requirements
- R1: A cycle starts on a clock edge that samples asN=0, csN=0 and at least one of udsN/ldsN at 0. For a read (rdWr=1), memRdEn is 1 for exactly the one cycle after that edge. With csN=1, or with both data strobes at 1, no cycle starts and memRdEn and memWrEn stay 0.
- R2: For a write (rdWr=0), memWrEn is driven for the one cycle after the start edge. Bit 1 is the upper byte and is set when udsN=0. Bit 0 is the lower byte and is set when ldsN=0.
- R3: On a read, dtackN, berrN and haltN stay 1 while chkDone is 0. The response appears after the first edge that samples chkDone=1, which is the third edge after the start at the earliest.
- R4: A verified read (chkDone=1, chkErr=0) drives dtackN=0 with berrN=1 and haltN=1.
- R5: A failed read (chkErr=1) with abortMode=0 and the retry count below RETRY_LIMIT drives berrN=0 and haltN=0 together, with dtackN=1.
- R6: A failed read with abortMode=1 drives berrN=0 and dtackN=0 in the same cycle, with haltN=1.
- R7: Each retry response increments a retry count. An error that arrives when the count equals RETRY_LIMIT gets the abort response of R6. Any non-retry response (verified read, abort, or write) clears the count.
- R8: A write is acknowledged (dtackN=0, berrN=1, haltN=1) after the second edge following the start, without waiting for chkDone.
- R9: dtackN, berrN and haltN are all 1 in any cycle where asN=1 or csN=1. After asN rises, a new cycle can start on the third following edge.
- R10: While rstN=0, and right after reset, all three responses are 1 and both memory enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| asN | input | 1 | Address strobe, active low |
| udsN | input | 1 | Upper byte data strobe, active low |
| ldsN | input | 1 | Lower byte data strobe, active low |
| rdWr | input | 1 | 1 = read, 0 = write |
| csN | input | 1 | Chip select, active low |
| chkDone | input | 1 | Checker has finished with the read word |
| chkErr | input | 1 | Checker found the read word invalid (valid with chkDone) |
| abortMode | input | 1 | 1 = close errors with bus-error plus acknowledge, 0 = retry |
| dtackN | output | 1 | Data acknowledge, active low |
| berrN | output | 1 | Bus error, active low |
| haltN | output | 1 | Halt, active low |
| memRdEn | output | 1 | Memory read enable |
| memWrEn | output | 2 | Byte-lane write enables, bit 1 upper, bit 0 lower |

## Verification
The bench drives inputs on falling edges and samples on the next falling edge. This places every result at a known count of rising edges after its stimulus. Memory enables are due one edge after the start. The write acknowledge is due two edges after the start. A read response is due one edge after the edge that samples chkDone, and the bench checks the outputs are still released during every earlier wait cycle. Strobe release is checked a fraction of a cycle after asN rises, before any clock edge, because the gating is combinational. The retry count is modelled in the bench and decides whether each error is expected to retry or abort.

// File: rtl/chkAckPkg.sv
package chkAckPkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ACCESS  = 3'd1,
    ST_CHECK   = 3'd2,
    ST_RESPOND = 3'd3,
    ST_RELEASE = 3'd4
  } ackState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic memRd;     // pulse the read enable
    logic memWr;     // pulse the selected lane write enables
    logic setOk;     // acknowledge only
    logic setRetry;  // bus-error plus halt
    logic setAbort;  // bus-error plus acknowledge
    logic clrResp;   // drop all held responses
  } ackStb_t;

  localparam int LANES = 2;

endpackage

// File: rtl/chkAckCtl.sv
module chkAckCtl
  import chkAckPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    asAct,
  input  logic    csAct,
  input  logic    strbAny,
  input  logic    isRead,
  input  logic    chkDone,
  input  logic    chkErr,
  input  logic    abortMode,
  input  logic    retryHit,
  output ackStb_t stb
);

  ackState_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    stb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (asAct && csAct && strbAny) stateNxt = ST_ACCESS;
      end
      ST_ACCESS: begin
        stb.memRd = isRead;
        stb.memWr = !isRead;
        if (!asAct) begin
          stateNxt = ST_RELEASE;
        end else if (isRead) begin
          stateNxt = ST_CHECK;
        end else begin
          stb.setOk = 1'b1;            // write latched this cycle
          stateNxt  = ST_RESPOND;
        end
      end
      ST_CHECK: begin
        if (!asAct) begin
          stateNxt = ST_RELEASE;
        end else if (chkDone) begin
          stateNxt = ST_RESPOND;
          if (!chkErr)                     stb.setOk    = 1'b1;
          else if (abortMode || retryHit)  stb.setAbort = 1'b1;
          else                             stb.setRetry = 1'b1;
        end
      end
      ST_RESPOND: begin
        if (!asAct) begin
          stb.clrResp = 1'b1;
          stateNxt    = ST_RELEASE;
        end
      end
      ST_RELEASE: begin
        stb.clrResp = 1'b1;
        stateNxt    = ST_IDLE;
      end
      default: begin
        stb.clrResp = 1'b1;
        stateNxt    = ST_IDLE;
      end
    endcase
  end

  AST_ACK_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RESPOND && $past(state) == ST_CHECK) |-> $past(chkDone)); // R3

  AST_ONE_ENABLE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.memRd, stb.memWr}));                                   // R1

endmodule

// File: rtl/chkAckDp.sv
module chkAckDp
  import chkAckPkg::*;
#(
  parameter int RETRY_LIMIT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ackStb_t          stb,
  input  logic             gateOn,
  input  logic [LANES-1:0] laneSel,
  output logic             retryHit,
  output logic             dtackN,
  output logic             berrN,
  output logic             haltN,
  output logic             memRdEn,
  output logic [LANES-1:0] memWrEn
);

  localparam int CNT_W = $clog2(RETRY_LIMIT + 2);

  logic             ackQ, berrQ, haltQ;
  logic [CNT_W-1:0] retryCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackQ  <= 1'b0;
      berrQ <= 1'b0;
      haltQ <= 1'b0;
    end else if (stb.clrResp) begin
      ackQ  <= 1'b0;
      berrQ <= 1'b0;
      haltQ <= 1'b0;
    end else if (stb.setOk) begin
      ackQ  <= 1'b1;
    end else if (stb.setAbort) begin
      ackQ  <= 1'b1;
      berrQ <= 1'b1;
    end else if (stb.setRetry) begin
      berrQ <= 1'b1;
      haltQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          retryCnt <= '0;
    else if (stb.setOk || stb.setAbort) retryCnt <= '0;
    else if (stb.setRetry)              retryCnt <= retryCnt + 1'b1;
  end

  assign retryHit = (retryCnt >= CNT_W'(RETRY_LIMIT));

  assign dtackN  = ~(ackQ  & gateOn);
  assign berrN   = ~(berrQ & gateOn);
  assign haltN   = ~(haltQ & gateOn);
  assign memRdEn = stb.memRd;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign memWrEn[g] = stb.memWr & laneSel[g];
  end

  AST_HALT_ONLY_RETRY: assert property (@(posedge clk) disable iff (!rstN)
    haltQ |-> (berrQ && !ackQ));                                         // R5

  AST_ABORT_HAS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (berrQ && !haltQ) |-> ackQ);                                         // R6

  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    retryCnt <= CNT_W'(RETRY_LIMIT));                                    // R7

endmodule

// File: rtl/chkAckCtrl.sv
module chkAckCtrl
  import chkAckPkg::*;
#(
  parameter int RETRY_LIMIT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       asN,
  input  logic       udsN,
  input  logic       ldsN,
  input  logic       rdWr,
  input  logic       csN,
  input  logic       chkDone,
  input  logic       chkErr,
  input  logic       abortMode,
  output logic       dtackN,
  output logic       berrN,
  output logic       haltN,
  output logic       memRdEn,
  output logic [1:0] memWrEn
);

  ackStb_t          stb;
  logic             retryHit;
  logic [LANES-1:0] laneSel;

  assign laneSel = {~udsN, ~ldsN};

  chkAckCtl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .asAct     (~asN),
    .csAct     (~csN),
    .strbAny   (|laneSel),
    .isRead    (rdWr),
    .chkDone   (chkDone),
    .chkErr    (chkErr),
    .abortMode (abortMode),
    .retryHit  (retryHit),
    .stb       (stb)
  );

  chkAckDp #(.RETRY_LIMIT(RETRY_LIMIT)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .gateOn   (~asN & ~csN),
    .laneSel  (laneSel),
    .retryHit (retryHit),
    .dtackN   (dtackN),
    .berrN    (berrN),
    .haltN    (haltN),
    .memRdEn  (memRdEn),
    .memWrEn  (memWrEn)
  );

  AST_STROBE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (asN || csN) |-> (dtackN && berrN && haltN));                        // R9

endmodule

// File: tb/sim_chkAckCtrl.sv
module sim_chkAckCtrl;

  localparam int CLK_PER = 10;
  localparam int LIM     = 2;

  logic clk = 1'b0;
  logic rstN, asN, udsN, ldsN, rdWr, csN, chkDone, chkErr, abortMode;
  logic dtackN, berrN, haltN, memRdEn;
  logic [1:0] memWrEn;

  int nChk = 0;
  int nBad = 0;
  int retries = 0;
  bit finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  chkAckCtrl #(.RETRY_LIMIT(LIM)) u0 (
    .clk(clk), .rstN(rstN), .asN(asN), .udsN(udsN), .ldsN(ldsN),
    .rdWr(rdWr), .csN(csN), .chkDone(chkDone), .chkErr(chkErr),
    .abortMode(abortMode), .dtackN(dtackN), .berrN(berrN), .haltN(haltN),
    .memRdEn(memRdEn), .memWrEn(memWrEn)
  );

  // observed vector: {dtackN, berrN, haltN, memRdEn, memWrEn[1:0]}
  localparam logic [5:0] V_IDLE  = 6'b111_0_00;
  localparam logic [5:0] V_RDACC = 6'b111_1_00;
  localparam logic [5:0] V_OK    = 6'b011_0_00;
  localparam logic [5:0] V_RETRY = 6'b100_0_00;
  localparam logic [5:0] V_ABORT = 6'b001_0_00;

  function automatic logic [5:0] obs();
    return {dtackN, berrN, haltN, memRdEn, memWrEn};
  endfunction

  task automatic chk(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = obs();
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idleBus();
    asN = 1'b1; udsN = 1'b1; ldsN = 1'b1; csN = 1'b1;
    rdWr = 1'b1; chkDone = 1'b0; chkErr = 1'b0;
  endtask

  task automatic releaseBus(input string req);
    asN = 1'b1; udsN = 1'b1; ldsN = 1'b1;
    #1 chk(req, V_IDLE);                     // R9: combinational release
    repeat (3) @(negedge clk);
  endtask

  task automatic doRead(input int lat, input bit err, input bit abortM);
    logic [5:0] exp;
    @(negedge clk);
    abortMode = abortM;
    asN = 1'b0; csN = 1'b0; rdWr = 1'b1; udsN = 1'b0; ldsN = 1'b0;
    chkDone = 1'b0; chkErr = 1'b0;
    @(negedge clk);
    chk("R1 read enable", V_RDACC);
    @(negedge clk);
    for (int i = 0; i < lat; i++) begin
      chk("R3 held during check", V_IDLE);
      @(negedge clk);
    end
    chk("R3 held during check", V_IDLE);
    chkDone = 1'b1; chkErr = err;
    if (!err) begin
      exp = V_OK; retries = 0;
    end else if (abortM || retries == LIM) begin
      exp = V_ABORT; retries = 0;
    end else begin
      exp = V_RETRY; retries++;
    end
    @(negedge clk);
    chkDone = 1'b0; chkErr = 1'b0;
    if (exp == V_OK)         chk("R4 verified read", exp);
    else if (exp == V_RETRY) chk("R5 retry response", exp);
    else if (abortM)         chk("R6 abort response", exp);
    else                     chk("R7 retry limit abort", exp);
    releaseBus("R9 release after read");
  endtask

  task automatic doWrite(input logic u, input logic l);
    @(negedge clk);
    asN = 1'b0; csN = 1'b0; rdWr = 1'b0; udsN = u; ldsN = l;
    chkDone = 1'b0;
    @(negedge clk);
    chk("R2 lane enables", {4'b1110, ~u, ~l});
    @(negedge clk);
    chk("R8 write ack", V_OK);
    retries = 0;
    releaseBus("R9 release after write");
  endtask

  initial begin
    idleBus();
    abortMode = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset state", V_IDLE);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 after reset", V_IDLE);

    // no chip select: nothing starts
    asN = 1'b0; csN = 1'b1; udsN = 1'b0; ldsN = 1'b0; rdWr = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 no start without chip select", V_IDLE);
    end
    // no data strobe: nothing starts
    csN = 1'b0; udsN = 1'b1; ldsN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 no start without data strobe", V_IDLE);
    end
    idleBus();
    @(negedge clk);

    // writes over the three strobe patterns
    doWrite(1'b0, 1'b0);
    doWrite(1'b0, 1'b1);
    doWrite(1'b1, 1'b0);

    // read sweep: mode x error x latency
    for (int m = 0; m < 2; m++)
      for (int e = 0; e < 2; e++)
        for (int lat = 0; lat < 4; lat++)
          doRead(lat, e[0], m[0]);

    // retry chain: two retries, then forced abort, then count restarts
    for (int k = 0; k < 5; k++) doRead(1, 1'b1, 1'b0);
    // a write clears the count: next error retries again
    doRead(0, 1'b1, 1'b0);
    doWrite(1'b0, 1'b0);
    doRead(0, 1'b1, 1'b0);
    doRead(2, 1'b0, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

endmodule